// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets a clocked host read and write a 64K-word, 16-bit asynchronous static RAM with two byte lanes. The host raises a request with an address, a write flag, one enable bit per byte lane and write data, and holds it until the controller answers with a one-cycle acknowledge. On a read, the acknowledge comes with the read data. On the memory side the controller drives the active-low chip select, output enable, write enable and per-lane strobes, plus the address. It also drives a data bus that is split into an outgoing word, an incoming word and a drive-enable, so the pad tri-state sits outside the block.

All memory-side timing is set in nanoseconds by parameters together with the clock period. A package function rounds each minimum up to whole clock cycles. A write holds write enable low for a release window in which the memory may still drive the bus, and only then turns the drivers on for the data-setup window. The drivers stay on through the cycle in which write enable returns high, which covers the zero-nanosecond hold. A read holds select and output enable for the access window, then registers the bus.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, chip select, output enable, write enable and both lane strobes are high, the data drive-enable is low and acknowledge is low.
- R2: A write with at least one lane enabled holds chip select, the enabled strobes and write enable low together for WHZ+DRV cycles. The data word is driven during the last DRV of those cycles, at least SU cycles, and the memory takes exactly one write.
- R3: The data drive-enable is never high while output enable is low. While write enable is low, it rises only after write enable has already been low for WHZ cycles.
- R4: In the cycle in which write enable returns high, the drivers stay on and the address, chip select and strobes are unchanged. In the following cycle the drivers are off.
- R5: A read holds chip select and output enable low, with write enable high, for RD cycles on a stable address. It registers the bus at the end of the last of those cycles, and the acknowledge cycle that follows presents that word on the read-data output.
- R6: Strobe bit 1 (upper lane, data bits 15..8) is low exactly when enable bit 1 is set, and strobe bit 0 (lower lane, bits 7..0) is low exactly when enable bit 0 is set. A write alters only the enabled lanes.
- R7: A lane whose enable bit is clear reads back as 8'h00, whatever the bus carries on that lane.
- R8: A write with both enable bits clear is acknowledged after the normal write length, starts no write overlap at the memory and leaves its contents unchanged.
- R9: Each request produces exactly one acknowledge, one cycle wide. A request is taken only while the controller is idle.
- R10: Write enable and output enable are never low in the same cycle. Write enable falls only after a cycle with output enable high, so a read followed by a write always has a turnaround cycle.
- R11: Each timing minimum becomes ceil(ns / period) cycles, with a floor of 1. DRV = max(SU, WP-WHZ, WC-1-WHZ, 1). Counting from the cycle in which the request is taken, a write is acknowledged WHZ+DRV+1 cycles later and a read RD+1 cycles later.
- R12: A request presented in the cycle right after an acknowledge is taken at the end of that cycle, with no extra wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Request, held until acknowledged |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_be | input | LANES (2) | Lane enables, bit 1 upper byte, bit 0 lower byte |
| host_addr | input | ADDR_W (16) | Word address |
| host_wdata | input | DATA_W (16) | Write data |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | DATA_W (16) | Read data, valid with acknowledge of a read |
| sram_addr | output | ADDR_W (16) | Memory address |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_bs_n | output | LANES (2) | Lane strobes, active low |
| sram_dq_o | output | DATA_W (16) | Outgoing data word |
| sram_dq_oe | output | 1 | Drive enable for the outgoing word |
| sram_dq_i | input | DATA_W (16) | Incoming data word |

## Verification
Two things happen in the same cycle: the write acknowledge and the end-of-write hold, in which write enable rises while the drivers, address and strobes stay put. A write answered late, or with the drivers already released, would look the same to the host but would corrupt the memory. The bench provokes this with back-to-back writes, each followed at once by a read of the same word. A bench memory model commits data only at the edge where the write overlap ends, and flags that edge if the drive-enable or the address has moved. The read-back and the model's own hold and setup counters then judge it.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WR_HZ   = 3'd1,
    ST_WR_DRV  = 3'd2,
    ST_WR_END  = 3'd3,
    ST_RD_WAIT = 3'd4,
    ST_RD_ACK  = 3'd5
  } asram_state_t;

  // Round a nanosecond minimum up to whole clock cycles, never below one.
  function automatic int asram_cycles(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  // Cycles of active drive inside the write-enable-low window.
  function automatic int asram_drive_cycles(input int wp, input int su,
                                            input int whz, input int wc);
    int d;
    d = su;
    if (wp - whz > d) d = wp - whz;
    if (wc - 1 - whz > d) d = wc - 1 - whz;
    if (d < 1) d = 1;
    return d;
  endfunction

  // Counter width able to hold the largest reload value.
  function automatic int asram_cnt_width(input int a, input int b, input int c);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return $clog2(m + 1);
  endfunction

endpackage

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
  import asram_pkg::*;
#(
  parameter int RD_CYC  = 2,
  parameter int WHZ_CYC = 1,
  parameter int DRV_CYC = 1,
  parameter int CNT_W   = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic         wr,
  output asram_state_t state_q,
  output asram_state_t state_d,
  output logic         accept,
  output logic         capture
);

  localparam logic [CNT_W-1:0] LD_RD  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] LD_WHZ = CNT_W'(WHZ_CYC - 1);
  localparam logic [CNT_W-1:0] LD_DRV = CNT_W'(DRV_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             last;

  function automatic logic [CNT_W-1:0] load_for(input asram_state_t s);
    case (s)
      ST_WR_HZ:   return LD_WHZ;
      ST_WR_DRV:  return LD_DRV;
      ST_RD_WAIT: return LD_RD;
      default:    return '0;
    endcase
  endfunction

  assign last    = (cnt_q == '0);
  assign accept  = (state_q == ST_IDLE) && req;
  assign capture = (state_q == ST_RD_WAIT) && last;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req) state_d = wr ? ST_WR_HZ : ST_RD_WAIT;
      ST_WR_HZ:   if (last) state_d = ST_WR_DRV;
      ST_WR_DRV:  if (last) state_d = ST_WR_END;
      ST_WR_END:  state_d = ST_IDLE;
      ST_RD_WAIT: if (last) state_d = ST_RD_ACK;
      ST_RD_ACK:  state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if (state_d != state_q)  cnt_d = load_for(state_d);
    else if (!last)          cnt_d = cnt_q - 1'b1;
    else                     cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // Length of the read window, counted independently of the reload counter.
  logic [CNT_W:0] rd_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      rd_run <= '0;
    else if (state_q == ST_RD_WAIT)  rd_run <= rd_run + 1'b1;
    else if (state_q == ST_IDLE)     rd_run <= '0;
  end

  p_rd_len_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_ACK) |-> (rd_run == (CNT_W+1)'(RD_CYC)));

  p_wr_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WR_END) |-> ($past(state_q) == ST_WR_DRV));

  p_rd_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_WAIT) |-> (cnt_q <= LD_RD));

  p_take_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && state_d != ST_IDLE) |-> req);

endmodule

// File: rtl/asram_lanes.sv
`timescale 1ns/1ps
module asram_lanes #(
  parameter int LANES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               capture,
  input  logic [LANES-1:0]   be_in,
  input  logic [LANES-1:0]   be_q,
  input  logic [LANES*8-1:0] wdata_in,
  input  logic [LANES*8-1:0] dq_in,
  output logic [LANES*8-1:0] dq_out,
  output logic [LANES*8-1:0] rdata
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    dq_out[g*8 +: 8] <= '0;
      else if (load) dq_out[g*8 +: 8] <= be_in[g] ? wdata_in[g*8 +: 8] : 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata[g*8 +: 8] <= '0;
      else if (capture) rdata[g*8 +: 8] <= be_q[g] ? dq_in[g*8 +: 8] : 8'h00;
    end
  end

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W           = 16,
  parameter int DATA_W           = 16,
  parameter int CLK_PERIOD_NS    = 8,
  parameter int T_ACCESS_NS      = 10,
  parameter int T_WE_PULSE_NS    = 8,
  parameter int T_DATA_SETUP_NS  = 6,
  parameter int T_WE_TO_HIZ_NS   = 5,
  parameter int T_WRITE_CYCLE_NS = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    host_req,
  input  logic                    host_wr,
  input  logic [DATA_W/8-1:0]     host_be,
  input  logic [ADDR_W-1:0]       host_addr,
  input  logic [DATA_W-1:0]       host_wdata,
  output logic                    host_ack,
  output logic [DATA_W-1:0]       host_rdata,
  output logic [ADDR_W-1:0]       sram_addr,
  output logic                    sram_ce_n,
  output logic                    sram_oe_n,
  output logic                    sram_we_n,
  output logic [DATA_W/8-1:0]     sram_bs_n,
  output logic [DATA_W-1:0]       sram_dq_o,
  output logic                    sram_dq_oe,
  input  logic [DATA_W-1:0]       sram_dq_i
);

  localparam int LANES   = DATA_W / 8;
  localparam int RD_CYC  = asram_cycles(T_ACCESS_NS, CLK_PERIOD_NS);
  localparam int WP_CYC  = asram_cycles(T_WE_PULSE_NS, CLK_PERIOD_NS);
  localparam int SU_CYC  = asram_cycles(T_DATA_SETUP_NS, CLK_PERIOD_NS);
  localparam int WHZ_CYC = asram_cycles(T_WE_TO_HIZ_NS, CLK_PERIOD_NS);
  localparam int WC_CYC  = asram_cycles(T_WRITE_CYCLE_NS, CLK_PERIOD_NS);
  localparam int DRV_CYC = asram_drive_cycles(WP_CYC, SU_CYC, WHZ_CYC, WC_CYC);
  localparam int CNT_W   = asram_cnt_width(RD_CYC, WHZ_CYC, DRV_CYC);

  asram_state_t state_q;
  asram_state_t state_d;
  logic         accept;
  logic         capture;

  asram_seq #(
    .RD_CYC (RD_CYC),
    .WHZ_CYC(WHZ_CYC),
    .DRV_CYC(DRV_CYC),
    .CNT_W  (CNT_W)
  ) i_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (host_req),
    .wr     (host_wr),
    .state_q(state_q),
    .state_d(state_d),
    .accept (accept),
    .capture(capture)
  );

  logic [LANES-1:0] be_q;
  logic [LANES-1:0] be_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      be_q      <= '0;
      sram_addr <= '0;
    end else if (accept) begin
      be_q      <= host_be;
      sram_addr <= host_addr;
    end
  end

  assign be_d = accept ? host_be : be_q;

  asram_lanes #(.LANES(LANES)) i_lanes (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .capture (capture),
    .be_in   (host_be),
    .be_q    (be_q),
    .wdata_in(host_wdata),
    .dq_in   (sram_dq_i),
    .dq_out  (sram_dq_o),
    .rdata   (host_rdata)
  );

  // Pin values decoded from the next state and registered, so pins are glitch-free.
  logic             sel_d;
  logic             we_low_d;
  logic             oe_low_d;
  logic             drive_d;
  logic             ack_d;

  always_comb begin
    sel_d    = state_d inside {ST_WR_HZ, ST_WR_DRV, ST_WR_END, ST_RD_WAIT};
    we_low_d = state_d inside {ST_WR_HZ, ST_WR_DRV};
    oe_low_d = (state_d == ST_RD_WAIT);
    drive_d  = state_d inside {ST_WR_DRV, ST_WR_END};
    ack_d    = state_d inside {ST_WR_END, ST_RD_ACK};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_ce_n  <= 1'b1;
      sram_oe_n  <= 1'b1;
      sram_we_n  <= 1'b1;
      sram_bs_n  <= '1;
      sram_dq_oe <= 1'b0;
      host_ack   <= 1'b0;
    end else begin
      sram_ce_n  <= !sel_d;
      sram_oe_n  <= !oe_low_d;
      sram_we_n  <= !we_low_d;
      sram_bs_n  <= sel_d ? ~be_d : '1;
      sram_dq_oe <= drive_d;
      host_ack   <= ack_d;
    end
  end

  p_no_clash_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n);

  p_drive_late_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_dq_oe && !sram_we_n) |-> !$past(sram_we_n));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (sram_dq_oe && !sram_ce_n && $stable(sram_addr) && $stable(sram_bs_n)));

  p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |=> !sram_dq_oe);

  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |=> !host_ack);

  p_rw_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sram_we_n && !sram_oe_n));

  p_turn_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_we_n) |-> $past(sram_oe_n));

  p_we_framed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_ce_n);

endmodule

// File: tb/test_asram_ctrl.sv
`timescale 1ns/1ps
module test_asram_ctrl;

  localparam int P      = 8;
  localparam int AA_NS  = 30;
  localparam int WP_NS  = 20;
  localparam int DS_NS  = 20;
  localparam int WHZ_NS = 12;
  localparam int WC_NS  = 10;

  function automatic int to_cyc(input int ns);
    int q;
    q = ns / P;
    if (ns % P != 0) q = q + 1;
    if (q == 0) q = 1;
    return q;
  endfunction

  localparam int E_RD  = to_cyc(AA_NS);
  localparam int E_WP  = to_cyc(WP_NS);
  localparam int E_SU  = to_cyc(DS_NS);
  localparam int E_WHZ = to_cyc(WHZ_NS);
  localparam int E_WC  = to_cyc(WC_NS);

  function automatic int calc_drv();
    int d;
    d = E_SU;
    if (E_WP - E_WHZ > d) d = E_WP - E_WHZ;
    if (E_WC - 1 - E_WHZ > d) d = E_WC - 1 - E_WHZ;
    if (d < 1) d = 1;
    return d;
  endfunction

  localparam int E_DRV  = calc_drv();
  localparam int LAT_WR = E_WHZ + E_DRV + 1;
  localparam int LAT_RD = E_RD + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        wr = 1'b0;
  logic [1:0]  be = 2'b00;
  logic [15:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        ack;
  logic [15:0] rdata;
  logic [15:0] mem_addr;
  logic        ce_n, oe_n, we_n, dq_oe;
  logic [1:0]  bs_n;
  logic [15:0] dq_o;
  logic [15:0] dq_i = 16'hEEEE;

  always #(P/2) clk = ~clk;

  asram_ctrl #(
    .CLK_PERIOD_NS(P), .T_ACCESS_NS(AA_NS), .T_WE_PULSE_NS(WP_NS),
    .T_DATA_SETUP_NS(DS_NS), .T_WE_TO_HIZ_NS(WHZ_NS), .T_WRITE_CYCLE_NS(WC_NS)
  ) i_asram_ctrl (
    .clk(clk), .rst_n(rst_n), .host_req(req), .host_wr(wr), .host_be(be),
    .host_addr(addr), .host_wdata(wdata), .host_ack(ack), .host_rdata(rdata),
    .sram_addr(mem_addr), .sram_ce_n(ce_n), .sram_oe_n(oe_n), .sram_we_n(we_n),
    .sram_bs_n(bs_n), .sram_dq_o(dq_o), .sram_dq_oe(dq_oe), .sram_dq_i(dq_i)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] init_word(input logic [15:0] a);
    return a ^ 16'h3C5A;
  endfunction

  // Memory model: storage, write commit at end of overlap, access-time gating.
  logic [15:0] model_mem [logic [15:0]];
  logic [15:0] shadow    [logic [15:0]];

  function automatic logic [15:0] model_get(input logic [15:0] a);
    if (model_mem.exists(a)) return model_mem[a];
    return init_word(a);
  endfunction

  function automatic logic [15:0] shadow_get(input logic [15:0] a);
    if (shadow.exists(a)) return shadow[a];
    return init_word(a);
  endfunction

  int commits = 0, we_low = 0, drv_run = 0, wact_len = 0, rd_cnt = 0;
  int clash_viol = 0, early_viol = 0, turn_viol = 0, hold_viol = 0, su_viol = 0, wp_viol = 0;
  bit prev_wact = 0, prev_commit = 0;
  logic prev_we_n = 1'b1, prev_oe_n = 1'b1;
  logic [15:0] prev_addr = '0, lat_addr = '0, lat_data = '0;
  logic [1:0]  lat_bs = 2'b11, obs_bs = 2'b11;

  always @(negedge clk) begin
    if (rst_n) begin
      bit wact;
      logic [15:0] w;
      wact = !ce_n && !we_n && (bs_n != 2'b11);
      if (!we_n) we_low++; else we_low = 0;
      if (!ce_n) obs_bs = bs_n;
      if (dq_oe && !oe_n) clash_viol++;
      if (dq_oe && !we_n && we_low <= E_WHZ) early_viol++;
      if (!we_n && prev_we_n && !prev_oe_n) turn_viol++;
      if (prev_commit && dq_oe) hold_viol++;
      prev_commit = 0;
      if (wact) begin
        lat_addr = mem_addr; lat_data = dq_o; lat_bs = bs_n;
        if (dq_oe) drv_run++; else drv_run = 0;
        wact_len++;
      end else if (prev_wact) begin
        if (!dq_oe || mem_addr != lat_addr) hold_viol++;
        if (drv_run < E_SU) su_viol++;
        if (wact_len < E_WP) wp_viol++;
        w = model_get(lat_addr);
        if (!lat_bs[0]) w[7:0]  = lat_data[7:0];
        if (!lat_bs[1]) w[15:8] = lat_data[15:8];
        model_mem[lat_addr] = w;
        commits++;
        drv_run = 0; wact_len = 0; prev_commit = 1;
      end
      if (!ce_n && !oe_n && we_n) begin
        if (rd_cnt > 0 && mem_addr == prev_addr) rd_cnt++; else rd_cnt = 1;
      end else rd_cnt = 0;
      w = model_get(mem_addr);
      dq_i[7:0]  <= (rd_cnt >= E_RD && !bs_n[0]) ? w[7:0]  : 8'hEE;
      dq_i[15:8] <= (rd_cnt >= E_RD && !bs_n[1]) ? w[15:8] : 8'hEE;
      prev_wact = wact; prev_we_n = we_n; prev_oe_n = oe_n; prev_addr = mem_addr;
    end
  end

  task automatic do_op(input bit w, input logic [1:0] b, input logic [15:0] a, input logic [15:0] d);
    int n;
    int c0;
    logic [15:0] e;
    @(negedge clk);
    check(ack == 1'b0, "R9 ack single cycle", ack, 0);
    c0 = commits;
    req = 1'b1; wr = w; be = b; addr = a; wdata = d;
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!ack && n < 64);
    req = 1'b0;
    #1;
    check(n == (w ? LAT_WR : LAT_RD), w ? "R11 R12 write latency" : "R11 R12 read latency",
          n, w ? LAT_WR : LAT_RD);
    check(obs_bs == ~b, "R6 strobe mapping", obs_bs, ~b);
    if (w) begin
      if (b == 2'b00) check(commits == c0, "R8 no write overlap", commits - c0, 0);
      else            check(commits == c0 + 1, "R2 single write", commits - c0, 1);
      e = shadow_get(a);
      if (b[0]) e[7:0]  = d[7:0];
      if (b[1]) e[15:8] = d[15:8];
      shadow[a] = e;
    end else begin
      e = shadow_get(a);
      if (!b[0]) e[7:0]  = 8'h00;
      if (!b[1]) e[15:8] = 8'h00;
      check(rdata == e, "R5 R7 read data", rdata, e);
    end
  endtask

  initial begin
    #(P * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [15:0] pool [8];
    seed = $urandom(32'd1234);
    pool[0] = 16'h0000; pool[1] = 16'hFFFF; pool[2] = 16'h8000; pool[3] = 16'h1234;
    pool[4] = 16'h0001; pool[5] = 16'h00FF; pool[6] = 16'h7FFE; pool[7] = 16'hABCD;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check({ce_n, oe_n, we_n, bs_n} == 5'b11111, "R1 idle pins", {ce_n, oe_n, we_n, bs_n}, 5'h1F);
    check({dq_oe, ack} == 2'b00, "R1 no drive no ack", {dq_oe, ack}, 0);

    // Directed corner cases
    do_op(1, 2'b11, 16'h0000, 16'hBEEF);
    do_op(0, 2'b11, 16'h0000, 16'h0);
    do_op(1, 2'b10, 16'hFFFF, 16'h12AB);   // upper lane only
    do_op(0, 2'b01, 16'hFFFF, 16'h0);      // R7 upper reads zero
    do_op(0, 2'b11, 16'hFFFF, 16'h0);      // R6 lower untouched
    do_op(1, 2'b00, 16'h1234, 16'hDEAD);   // R8 no lanes
    do_op(0, 2'b11, 16'h1234, 16'h0);
    do_op(0, 2'b00, 16'h1234, 16'h0);      // R7 both zero
    do_op(0, 2'b11, 16'h8000, 16'h0);      // R10 read then write
    do_op(1, 2'b01, 16'h8000, 16'h5566);
    do_op(0, 2'b11, 16'h8000, 16'h0);

    // Random mix with back-to-back requests
    for (int i = 0; i < 300; i++) begin
      int gap;
      logic [15:0] a;
      a = ($urandom % 4 == 0) ? 16'($urandom) : pool[$urandom % 8];
      do_op(1'($urandom), 2'($urandom), a, 16'($urandom));
      gap = $urandom % 3;
      repeat (gap) @(negedge clk);
    end

    #1;
    check(clash_viol == 0, "R3 drive with output enable low", clash_viol, 0);
    check(early_viol == 0, "R3 drive before release window", early_viol, 0);
    check(hold_viol == 0, "R4 hold at write end", hold_viol, 0);
    check(su_viol == 0, "R2 data setup cycles", su_viol, 0);
    check(wp_viol == 0, "R11 write pulse cycles", wp_viol, 0);
    check(turn_viol == 0, "R10 turnaround cycle", turn_viol, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule